// File: doc/BRIEF.md
# Single-Error-Correcting Register with Write-Back Scrub

This block is a single storage register guarded against bit upsets. When chip enable is high, the incoming data word is encoded and stored at the next clock edge. The encoding adds Hamming check bits and one overall parity bit. The stored word is decoded all the time, so the data output always shows the decoded value. A 2-bit status tells whether that value came back clean, was repaired, or could not be trusted.

A single flipped bit may sit in a data bit, a Hamming bit or the overall parity bit. In each case the output carries the repaired data in the same cycle. On the next edge with chip enable low, the repaired word is written back into the register. A double flip is detected but cannot be located, so the register is left untouched until a new write replaces it. The data width is a parameter, and the number of check bits follows from it.

Top module: `secded_reg`

## Requirements
- R1: While rst_ni is low, the stored word is all zeros, so data_o reads 0 and err_o reads 00.
- R2: A clock edge with ce_i high stores data_i. After that edge, data_o equals that data_i and err_o is 00.
- R3: A clock edge with ce_i low and a clean stored word leaves the register unchanged, whatever data_i holds.
- R4: The stored word has DATA_W + P + 1 bits. P is the smallest count with 2^P >= DATA_W + P + 1. The overall parity bit is at bit 0, and Hamming position k is at bit k. For DATA_W = 8 this gives 13 bits.
- R5: Flipping any single bit of the stored word, including bit 0, makes err_o read 01 in the same cycle, and data_o still shows the written data.
- R6: After a clock edge with ce_i low while err_o is 01, the register holds the repaired word. err_o then reads 00 with the same data_o, and a later single flip is again repairable.
- R7: Any two flipped bits make err_o read 10. No write-back happens, so the status stays 10 until a write with ce_i high stores a new word.
- R8: If ce_i is high at the same edge where a repair is pending, data_i is stored and the repaired word is discarded.
- R9: Status codes are 00 for clean, 01 for repaired and 10 for uncorrectable. The value 11 never appears.
- R10: With DATA_W = 32 the stored word is 39 bits, with 6 Hamming bits and 1 overall parity bit. Single flips at both ends of that word are repaired, and a double flip is reported as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable; a high level writes data_i |
| data_i | input | DATA_W | Data to store |
| data_o | output | DATA_W | Decoded, corrected data |
| err_o | output | 2 | Status: 00 clean, 01 repaired, 10 uncorrectable |

## Verification
A wrong stored word or a broken decoder is visible at the ports in the same cycle. err_o takes a wrong code, or data_o differs from the last written value after a single flip. A failed write-back shows one cycle later: err_o stays at 01 instead of returning to 00. A failed write-back also shows when the next single flip is injected and reads as a double error, 10. The bench emulates upsets by overriding the stored word for an instant between clock edges. It walks a flip through every stored bit, applies several double flips, and applies a flip together with a same-edge write.

// File: rtl/secded_pkg.sv
package secded_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_FIXED = 2'b01,
    ERR_FATAL = 2'b10
  } err_e;

  // smallest p with 2^p >= dw + p + 1
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc import secded_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int P  = hamming_bits(DATA_W),
  localparam int N  = DATA_W + P,
  localparam int CW = N + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     code_o
);
  logic [N:1] h;

  always_comb begin
    int k;
    h = '0;
    k = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        h[pos] = data_i[k];
        k++;
      end
    end
    // each check bit covers the positions whose index has bit i set
    for (int i = 0; i < P; i++) begin
      logic b;
      b = 1'b0;
      for (int pos = 1; pos <= N; pos++)
        if (((pos >> i) & 1) == 1) b = b ^ h[pos];
      h[1 << i] = b;
    end
    code_o = {h, ^h};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec import secded_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int P  = hamming_bits(DATA_W),
  localparam int N  = DATA_W + P,
  localparam int CW = N + 1
) (
  input  logic [CW-1:0]     code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     fixed_o,
  output err_e              err_o
);
  logic [P-1:0]  syn;
  logic          odd;
  logic [CW-1:0] flip;

  always_comb begin
    syn = '0;
    for (int i = 0; i < P; i++)
      for (int pos = 1; pos <= N; pos++)
        if (((pos >> i) & 1) == 1) syn[i] = syn[i] ^ code_i[pos];
    odd = ^code_i;
  end

  always_comb begin
    int idx;
    idx   = int'(syn);
    flip  = '0;
    err_o = ERR_NONE;
    if (odd) begin
      // zero syndrome with odd weight: the overall parity bit itself flipped
      if (idx == 0) begin
        flip[0] = 1'b1;
        err_o   = ERR_FIXED;
      end else if (idx <= N) begin
        flip[idx] = 1'b1;
        err_o     = ERR_FIXED;
      end else begin
        err_o = ERR_FATAL;
      end
    end else if (idx != 0) begin
      err_o = ERR_FATAL;
    end
    fixed_o = code_i ^ flip;
  end

  always_comb begin
    int k;
    data_o = '0;
    k = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        data_o[k] = fixed_o[pos];
        k++;
      end
    end
  end
endmodule

// File: rtl/secded_reg.sv
module secded_reg import secded_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        err_o
);
  localparam int P  = hamming_bits(DATA_W);
  localparam int CW = DATA_W + P + 1;

  logic [CW-1:0] stored_q;
  logic [CW-1:0] wr_code;
  logic [CW-1:0] fixed;
  err_e          status;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (data_i),
    .code_o (wr_code)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code_i  (stored_q),
    .data_o  (data_o),
    .fixed_o (fixed),
    .err_o   (status)
  );

  // external write wins over scrub write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 stored_q <= '0;
    else if (ce_i)               stored_q <= wr_code;
    else if (status == ERR_FIXED) stored_q <= fixed;
  end

  assign err_o = status;

  // R2, R8: a write always lands clean, even over a pending repair
  p_write_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> (err_o == ERR_NONE && data_o == $past(data_i)));

  p_scrub_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && err_o == ERR_FIXED) |=> (err_o == ERR_NONE && data_o == $past(data_o)));

  p_double_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && err_o == ERR_FATAL) |=> (err_o == ERR_FATAL));

  p_no_code3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o != 2'b11);
endmodule

// File: tb/secded_reg_tb.sv
module secded_reg_tb;
  localparam int CLK_P = 10;

  typedef struct {
    bit          wide;
    logic [31:0] d;
    logic [1:0]  e;
    bit          chk_d;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce = 1'b0, ce_w = 1'b0;
  logic [7:0]  din = '0, dout;
  logic [31:0] din_w = '0, dout_w;
  logic [1:0]  err, err_w;
  logic [12:0] inj8;
  logic [38:0] inj39;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;

  secded_reg #(.DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .data_i(din), .data_o(dout), .err_o(err)
  );

  secded_reg #(.DATA_W(32)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_w), .data_i(din_w), .data_o(dout_w), .err_o(err_w)
  );

  // monitor: compare queued expectations after the outputs settle
  always begin
    @(negedge clk);
    #(CLK_P/4);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] ad;
      logic [1:0]  ae;
      it = q.pop_front();
      ad = it.wide ? dout_w : {24'd0, dout};
      ae = it.wide ? err_w : err;
      checks++;
      if (ae !== it.e || (it.chk_d && ad !== it.d)) begin
        errors++;
        $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                 it.tag, ad, ae, it.d, it.e);
      end
    end
  end

  task automatic push(input bit w, input logic [31:0] d, input logic [1:0] e,
                      input bit cd, input string tag);
    item_t it;
    it.wide = w; it.d = d; it.e = e; it.chk_d = cd; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr8(input logic [7:0] d);
    @(negedge clk); ce = 1'b1; din = d;
    @(negedge clk); ce = 1'b0;
  endtask

  task automatic wr32(input logic [31:0] d);
    @(negedge clk); ce_w = 1'b1; din_w = d;
    @(negedge clk); ce_w = 1'b0;
  endtask

  task automatic flip8(input logic [12:0] m);
    @(negedge clk);
    inj8 = u_dut.stored_q ^ m;
    force u_dut.stored_q = inj8;
    #1 release u_dut.stored_q;
  endtask

  task automatic flip32(input logic [38:0] m);
    @(negedge clk);
    inj39 = u_dut_w.stored_q ^ m;
    force u_dut_w.stored_q = inj39;
    #1 release u_dut_w.stored_q;
  endtask

  initial begin
    repeat (2) step();
    push(0, 0, 2'b00, 1, "R1");
    push(1, 0, 2'b00, 1, "R1");
    step();
    rst_ni = 1'b1;

    wr8(8'hA5); push(0, 8'hA5, 2'b00, 1, "R2");
    wr8(8'h3C); push(0, 8'h3C, 2'b00, 1, "R2");

    // R3: data_i toggles with ce low
    step(); din = 8'hFF;
    step(); push(0, 8'h3C, 2'b00, 1, "R3");
    din = 8'h00;
    step(); push(0, 8'h3C, 2'b00, 1, "R3");

    // R4/R5/R6: walk a single flip through all 13 stored bits
    for (int b = 0; b < 13; b++) begin
      flip8(13'd1 << b); push(0, 8'h3C, 2'b01, 1, "R5");
      step();            push(0, 8'h3C, 2'b00, 1, "R6");
    end
    flip8(13'h1000); push(0, 8'h3C, 2'b01, 1, "R4");
    step();          push(0, 8'h3C, 2'b00, 1, "R4");

    // R7: double flips persist until rewritten
    wr8(8'h5A); push(0, 8'h5A, 2'b00, 1, "R2");
    flip8(13'h0081); push(0, 0, 2'b10, 0, "R7");
    step();          push(0, 0, 2'b10, 0, "R7");
    step();          push(0, 0, 2'b10, 0, "R9");
    wr8(8'h81);      push(0, 8'h81, 2'b00, 1, "R7");
    flip8(13'h0204); push(0, 0, 2'b10, 0, "R7");
    step();          push(0, 0, 2'b10, 0, "R7");
    wr8(8'h81);
    flip8(13'h1800); push(0, 0, 2'b10, 0, "R7");
    wr8(8'h77);      push(0, 8'h77, 2'b00, 1, "R7");

    // R8: write and pending repair at the same edge
    wr8(8'h11);
    @(negedge clk);
    inj8 = u_dut.stored_q ^ 13'h0020;
    force u_dut.stored_q = inj8;
    #1 release u_dut.stored_q;
    ce = 1'b1; din = 8'hEE;
    push(0, 8'h11, 2'b01, 1, "R5");
    @(negedge clk); ce = 1'b0;
    push(0, 8'hEE, 2'b00, 1, "R8");

    // R10: widened word
    wr32(32'hDEADBEEF); push(1, 32'hDEADBEEF, 2'b00, 1, "R10");
    flip32(39'd1 << 38); push(1, 32'hDEADBEEF, 2'b01, 1, "R10");
    step();              push(1, 32'hDEADBEEF, 2'b00, 1, "R10");
    flip32(39'd1);       push(1, 32'hDEADBEEF, 2'b01, 1, "R10");
    step();              push(1, 32'hDEADBEEF, 2'b00, 1, "R10");
    flip32(39'd1 << 20); push(1, 32'hDEADBEEF, 2'b01, 1, "R10");
    step();              push(1, 32'hDEADBEEF, 2'b00, 1, "R10");
    flip32((39'd1 << 20) | 39'd2); push(1, 0, 2'b10, 0, "R10");
    wr32(32'h0F0F1234); push(1, 32'h0F0F1234, 2'b00, 1, "R10");

    step();
    #(CLK_P/2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule